// File: doc/BRIEF.md
# Nested Segment-Insertion Scan Network

This block is a small on-chip instrument access network that sits behind a test access port. The port's controller supplies the test clock, a global reset, a network-select qualifier (high while the instruction register decodes this network), serial data in, and one-cycle capture, shift and update strobes. The block returns one serial data output and drives static control levels into the instruments it serves.

The top chain has two segment-insertion bits in series. The first guards the scan-tested instrument group. The second guards the scan-resource group, and behind it sit a 4-bit core-control register and two more insertion bits, each guarding an 8-bit instrument register. Every element has a shift stage and a hold stage. A closed insertion bit hides its segment, so the network is reached step by step. One data scan opens the scan-resource bit. A second scan, now longer, fills the newly visible children, and its update moves their values to the hold stages that drive the instrument pins.

Top module: `sib_net_top`

## Requirements
- R1: Global reset (rst_n low, asynchronous) clears every shift and hold stage. All insertion bits are then closed, and scan_out, sti_open, sri_open, inst_a_ctrl, inst_b_ctrl and core_ctrl read 0.
- R2: With every insertion bit closed, the chain is 2 bits long. A 1 shifted in on scan_in first shows on scan_out after exactly 2 shift cycles.
- R3: With only the scan-resource bit open, the chain is 8 bits long. From scan_out backwards the order is: scan-resource bit, core_ctrl bit 0 to bit 3, instrument-B insertion bit, instrument-A insertion bit, scan-tested bit. So the first bit shifted in ends in the scan-resource bit.
- R4: An update with net_sel high copies each selected shift stage into its hold stage. A hold of 1 in the scan-resource bit (sri_open) selects the core-control register and both child insertion bits. While sri_open is 0, no child hold stage changes.
- R5: A second scan into the opened segment, followed by an update, makes core_ctrl equal the 4 bits shifted into its positions.
- R6: Each instrument register is in the chain only while its own insertion bit is open. The register sits just before that bit, bit 0 nearest the bit. This makes the chain 16 bits with one child open and 24 bits with both open.
- R7: A capture loads every selected shift stage from its hold stage, so the next shifts read back the current settings in chain order.
- R8: While net_sel is low, capture, shift and update have no effect on any stage.
- R9: Hold values persist after their parent bit closes until the next reset. While the parent is closed, child shift stages are left untouched.
- R10: When shift and update fall in the same cycle, the hold stage takes the shift-stage content from before that cycle's shift.
- R11: When capture and shift fall in the same cycle, capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Global reset, active low, asynchronous |
| net_sel | input | 1 | Network selected by the current instruction |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| scan_in | input | 1 | Serial data in |
| scan_out | output | 1 | Serial data out (scan-resource bit shift stage) |
| sti_open | output | 1 | Hold of the scan-tested insertion bit |
| sri_open | output | 1 | Hold of the scan-resource insertion bit |
| inst_a_ctrl | output | 8 | Hold of instrument register A |
| inst_b_ctrl | output | 8 | Hold of instrument register B |
| core_ctrl | output | 4 | Hold of the core-control register |

## Verification
Shift and update can land in the same cycle, and so can capture and shift. The port controller never does this, but the block defines the result. Random phases raise these pairs often on purpose, one pair per phase. A cycle-by-cycle bench model, written from the requirements, predicts scan_out and every hold output after each edge. Directed scans first open the hierarchy level by level, measuring chain length as the number of shifts a lone 1 needs to reach scan_out.

// File: rtl/sib_net_pkg.sv
package sib_net_pkg;
  localparam int INST_W = 8;
  localparam int CTRL_W = 4;
  localparam int N_INST = 2;

  typedef struct packed {
    logic cap;
    logic shf;
    logic upd;
  } scan_ctl_t;
endpackage

// File: rtl/scan_reg.sv
module scan_reg #(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  sib_net_pkg::scan_ctl_t ctl,
  input  logic                  si,
  output logic                  so,
  output logic [W-1:0]          hold
);
  logic [W-1:0] sr_q, hr_q, sr_nxt;

  generate
    if (W == 1) begin : g_bit
      assign sr_nxt = si;
    end else begin : g_vec
      assign sr_nxt = {si, sr_q[W-1:1]};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
      hr_q <= '0;
    end else if (sel) begin
      if (ctl.cap)      sr_q <= hr_q;
      else if (ctl.shf) sr_q <= sr_nxt;
      if (ctl.upd)      hr_q <= sr_q;
    end
  end

  assign so   = sr_q[0];
  assign hold = hr_q;

  // R8 / R9: an unselected or idle stage keeps its contents
  assert_hold_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && ctl.upd) |=> $stable(hold));
  assert_shift_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel && (ctl.cap || ctl.shf)) |=> $stable(sr_q));
endmodule

// File: rtl/sib_cell.sv
module sib_cell (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sel,
  input  sib_net_pkg::scan_ctl_t ctl,
  input  logic                  si,
  input  logic                  seg_so,
  output logic                  so,
  output logic                  open
);
  logic path_in;
  logic bit_hold;

  assign path_in = open ? seg_so : si;

  scan_reg #(.W(1)) u_bit (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .ctl   (ctl),
    .si    (path_in),
    .so    (so),
    .hold  (bit_hold)
  );

  assign open = bit_hold;

  // R6: a closed bit bypasses its segment
  assert_closed_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && ctl.shf && !ctl.cap && !open) |=> (so == $past(si)));
endmodule

// File: rtl/sri_segment.sv
module sri_segment
  import sib_net_pkg::*;
(
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             sel,
  input  scan_ctl_t                        ctl,
  input  logic                             si,
  output logic                             so,
  output logic [N_INST-1:0][INST_W-1:0]    inst_ctrl,
  output logic [CTRL_W-1:0]                core_ctrl
);
  logic [N_INST:0]   link;
  logic [N_INST-1:0] reg_so;
  logic [N_INST-1:0] open;

  assign link[0] = si;

  generate
    for (genvar i = 0; i < N_INST; i++) begin : g_inst
      scan_reg #(.W(INST_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel & open[i]),
        .ctl   (ctl),
        .si    (link[i]),
        .so    (reg_so[i]),
        .hold  (inst_ctrl[i])
      );
      sib_cell u_sib (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (sel),
        .ctl    (ctl),
        .si     (link[i]),
        .seg_so (reg_so[i]),
        .so     (link[i+1]),
        .open   (open[i])
      );
    end
  endgenerate

  scan_reg #(.W(CTRL_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (sel),
    .ctl   (ctl),
    .si    (link[N_INST]),
    .so    (so),
    .hold  (core_ctrl)
  );
endmodule

// File: rtl/sib_net_top.sv
module sib_net_top
  import sib_net_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              net_sel,
  input  logic              cap_en,
  input  logic              shf_en,
  input  logic              upd_en,
  input  logic              scan_in,
  output logic              scan_out,
  output logic              sti_open,
  output logic              sri_open,
  output logic [INST_W-1:0] inst_a_ctrl,
  output logic [INST_W-1:0] inst_b_ctrl,
  output logic [CTRL_W-1:0] core_ctrl
);
  scan_ctl_t ctl;
  logic      sti_so;
  logic      seg_so;
  logic [N_INST-1:0][INST_W-1:0] inst_ctrl;

  assign ctl = '{cap: cap_en, shf: shf_en, upd: upd_en};

  // scan-tested group: its segment lies outside this block, so the bit loops on itself
  sib_cell u_sti (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (net_sel),
    .ctl    (ctl),
    .si     (scan_in),
    .seg_so (scan_in),
    .so     (sti_so),
    .open   (sti_open)
  );

  sri_segment u_seg (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (net_sel & sri_open),
    .ctl       (ctl),
    .si        (sti_so),
    .so        (seg_so),
    .inst_ctrl (inst_ctrl),
    .core_ctrl (core_ctrl)
  );

  sib_cell u_sri (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (net_sel),
    .ctl    (ctl),
    .si     (sti_so),
    .seg_so (seg_so),
    .so     (scan_out),
    .open   (sri_open)
  );

  assign inst_a_ctrl = inst_ctrl[0];
  assign inst_b_ctrl = inst_ctrl[1];

  // R4: children of a closed parent never update
  assert_child_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !sri_open |=> ($stable(inst_a_ctrl) && $stable(inst_b_ctrl) && $stable(core_ctrl)));
  // R8: a deselected network holds its top bits
  assert_desel_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !net_sel |=> ($stable(sti_open) && $stable(sri_open)));
endmodule

// File: tb/tb_sib_net_top.sv
`timescale 1ns/1ps
module tb_sib_net_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic net_sel = 1'b0, cap_en = 1'b0, shf_en = 1'b0, upd_en = 1'b0, scan_in = 1'b0;
  logic scan_out, sti_open, sri_open;
  logic [7:0] inst_a_ctrl, inst_b_ctrl;
  logic [3:0] core_ctrl;

  int n_chk = 0;
  int n_bad = 0;
  string cur_req = "R1";

  sib_net_top dut (.*);

  always #10 clk = ~clk;

  // reference model state
  logic m_sti_s, m_sti_h, m_sri_s, m_sri_h, m_a_s, m_a_h, m_b_s, m_b_h;
  logic [7:0] m_ra_s, m_ra_h, m_rb_s, m_rb_h;
  logic [3:0] m_c_s, m_c_h;

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nx8(logic e, logic c, logic sh, logic [7:0] s, logic [7:0] h, logic d);
    if (e && c) return h;
    if (e && sh) return {d, s[7:1]};
    return s;
  endfunction
  function automatic logic [3:0] nx4(logic e, logic c, logic sh, logic [3:0] s, logic [3:0] h, logic d);
    if (e && c) return h;
    if (e && sh) return {d, s[3:1]};
    return s;
  endfunction
  function automatic logic nx1(logic e, logic c, logic sh, logic s, logic h, logic d);
    if (e && c) return h;
    if (e && sh) return d;
    return s;
  endfunction

  task automatic model_reset();
    {m_sti_s, m_sti_h, m_sri_s, m_sri_h, m_a_s, m_a_h, m_b_s, m_b_h} = '0;
    {m_ra_s, m_ra_h, m_rb_s, m_rb_h, m_c_s, m_c_h} = '0;
  endtask

  task automatic model_step(input logic s, input logic c, input logic sh, input logic u, input logic d);
    logic e0, e1, ea, eb, a_in, b_in, sri_in;
    logic o_sti_s, o_sri_s, o_a_s, o_b_s;
    logic [7:0] o_ra_s, o_rb_s;
    logic [3:0] o_c_s;
    e0 = s; e1 = s & m_sri_h; ea = e1 & m_a_h; eb = e1 & m_b_h;
    o_sti_s = m_sti_s; o_sri_s = m_sri_s; o_a_s = m_a_s; o_b_s = m_b_s;
    o_ra_s = m_ra_s; o_rb_s = m_rb_s; o_c_s = m_c_s;
    a_in   = m_a_h ? o_ra_s[0] : o_sti_s;
    b_in   = m_b_h ? o_rb_s[0] : o_a_s;
    sri_in = m_sri_h ? o_c_s[0] : o_sti_s;
    m_sti_s = nx1(e0, c, sh, o_sti_s, m_sti_h, d);
    m_sri_s = nx1(e0, c, sh, o_sri_s, m_sri_h, sri_in);
    m_a_s   = nx1(e1, c, sh, o_a_s, m_a_h, a_in);
    m_b_s   = nx1(e1, c, sh, o_b_s, m_b_h, b_in);
    m_ra_s  = nx8(ea, c, sh, o_ra_s, m_ra_h, o_sti_s);
    m_rb_s  = nx8(eb, c, sh, o_rb_s, m_rb_h, o_a_s);
    m_c_s   = nx4(e1, c, sh, o_c_s, m_c_h, o_b_s);
    if (e0 && u) begin m_sti_h = o_sti_s; m_sri_h = o_sri_s; end
    if (e1 && u) begin m_a_h = o_a_s; m_b_h = o_b_s; m_c_h = o_c_s; end
    if (ea && u) m_ra_h = o_ra_s;
    if (eb && u) m_rb_h = o_rb_s;
  endtask

  task automatic cmp_model();
    logic ok;
    ok = (scan_out === m_sri_s) && (sti_open === m_sti_h) && (sri_open === m_sri_h) &&
         (inst_a_ctrl === m_ra_h) && (inst_b_ctrl === m_rb_h) && (core_ctrl === m_c_h);
    chk(ok, cur_req, "ports vs model",
        {3'b0, scan_out, sti_open, sri_open, core_ctrl, inst_b_ctrl, inst_a_ctrl, 6'b0},
        {3'b0, m_sri_s, m_sti_h, m_sri_h, m_c_h, m_rb_h, m_ra_h, 6'b0});
  endtask

  // drive at a falling edge, model at the rising edge, compare at the next falling edge
  task automatic cyc(input logic s, input logic c, input logic sh, input logic u, input logic d);
    net_sel = s; cap_en = c; shf_en = sh; upd_en = u; scan_in = d;
    @(posedge clk);
    model_step(s, c, sh, u, d);
    @(negedge clk);
    cmp_model();
  endtask

  task automatic scan_vec(input logic [31:0] v, input int n);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < n; i++) cyc(1, 0, 1, 0, v[i]);
    cyc(1, 0, 0, 1, 0);
    cyc(1, 0, 0, 0, 0);
  endtask

  task automatic measure(input int exp_len, input string req);
    int n;
    for (int i = 0; i < 30; i++) cyc(1, 0, 1, 0, 0);
    cyc(1, 0, 1, 0, 1);
    n = 1;
    while (scan_out !== 1'b1 && n < 64) begin
      cyc(1, 0, 1, 0, 0);
      n++;
    end
    chk(n == exp_len, req, "chain length", n, exp_len);
  endtask

  // chain image, first bit shifted in = index 0 = bit nearest scan_out
  function automatic logic [31:0] build(logic aop, logic bop, logic sri, logic [3:0] c,
                                        logic b, logic [7:0] rb, logic a, logic [7:0] ra, logic sti);
    logic [31:0] v;
    int k;
    v = '0; k = 0;
    v[k] = sri; k++;
    for (int i = 0; i < 4; i++) begin v[k] = c[i]; k++; end
    v[k] = b; k++;
    if (bop) for (int i = 0; i < 8; i++) begin v[k] = rb[i]; k++; end
    v[k] = a; k++;
    if (aop) for (int i = 0; i < 8; i++) begin v[k] = ra[i]; k++; end
    v[k] = sti;
    return v;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    net_sel = 0; cap_en = 0; shf_en = 0; upd_en = 0; scan_in = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v, rd;
    logic [7:0] sa, sb; logic [3:0] sc;
    void'($urandom(32'h1687_5EED));
    do_reset();
    // R1 reset state
    chk({scan_out, sti_open, sri_open, inst_a_ctrl, inst_b_ctrl, core_ctrl} == '0,
        "R1", "reset outputs", {scan_out, sti_open, sri_open, inst_a_ctrl, inst_b_ctrl, core_ctrl}, 0);
    cur_req = "R2"; measure(2, "R2");
    // R4 open the scan-resource bit
    cur_req = "R4"; scan_vec(32'b01, 2);
    chk(sri_open === 1'b1 && sti_open === 1'b0, "R4", "sri open only", {sti_open, sri_open}, 2'b01);
    cur_req = "R3"; measure(8, "R3");
    // R5 second scan into the segment, also opens child A
    cur_req = "R5";
    scan_vec(build(0, 0, 1, 4'hA, 0, 8'h00, 1, 8'h00, 0), 8);
    chk(core_ctrl === 4'hA, "R5", "core_ctrl", core_ctrl, 4'hA);
    cur_req = "R6"; measure(16, "R6");
    scan_vec(build(1, 0, 1, 4'hA, 1, 8'h00, 1, 8'h5C, 0), 16);
    chk(inst_a_ctrl === 8'h5C, "R6", "inst_a_ctrl", inst_a_ctrl, 8'h5C);
    chk(inst_b_ctrl === 8'h00, "R6", "inst_b_ctrl untouched", inst_b_ctrl, 0);
    measure(24, "R6");
    scan_vec(build(1, 1, 1, 4'h6, 1, 8'h3E, 1, 8'hC3, 0), 24);
    chk(inst_a_ctrl === 8'hC3 && inst_b_ctrl === 8'h3E && core_ctrl === 4'h6, "R5", "all holds",
        {core_ctrl, inst_b_ctrl, inst_a_ctrl}, {4'h6, 8'h3E, 8'hC3});
    // R7 capture read-back
    cur_req = "R7";
    cyc(1, 1, 0, 0, 0);
    rd = '0; rd[0] = scan_out;
    for (int i = 1; i < 24; i++) begin cyc(1, 0, 1, 0, 0); rd[i] = scan_out; end
    v = build(1, 1, 1, 4'h6, 1, 8'h3E, 1, 8'hC3, 0);
    chk(rd[23:0] === v[23:0], "R7", "read-back", rd, v);
    // R9 close the parent, children persist
    cur_req = "R9";
    scan_vec(build(1, 1, 0, 4'h6, 1, 8'h3E, 1, 8'hC3, 0), 24);
    chk(sri_open === 1'b0, "R9", "sri closed", sri_open, 0);
    measure(2, "R9");
    scan_vec(32'b10, 2);
    chk(sti_open === 1'b1 && inst_a_ctrl === 8'hC3 && inst_b_ctrl === 8'h3E && core_ctrl === 4'h6,
        "R9", "holds persist", {sti_open, core_ctrl, inst_b_ctrl, inst_a_ctrl}, {1'b1, 4'h6, 8'h3E, 8'hC3});
    // R8 deselected network ignores strobes
    cur_req = "R8";
    for (int i = 0; i < 40; i++)
      cyc(0, 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
    chk(sti_open === 1'b1 && sri_open === 1'b0 && core_ctrl === 4'h6 && inst_a_ctrl === 8'hC3,
        "R8", "no change while deselected", {sti_open, sri_open, core_ctrl, inst_a_ctrl},
        {1'b1, 1'b0, 4'h6, 8'hC3});
    measure(2, "R8");
    // R11 capture and shift together, random
    do_reset();
    cur_req = "R11";
    for (int i = 0; i < 3000; i++) begin
      logic c, sh;
      c = ($urandom % 4) == 0; sh = ($urandom % 4) != 0;
      cyc(($urandom % 10) != 0, c, c ? 1'b1 : sh, ($urandom % 6) == 0, 1'($urandom % 2));
    end
    // R10 shift and update together, random
    cur_req = "R10";
    for (int i = 0; i < 3000; i++) begin
      logic u;
      u = ($urandom % 5) == 0;
      cyc(($urandom % 10) != 0, ($urandom % 12) == 0, u ? 1'b1 : 1'($urandom % 2), u, 1'($urandom % 2));
    end
    sa = inst_a_ctrl; sb = inst_b_ctrl; sc = core_ctrl;
    cyc(1, 0, 0, 0, 0);
    chk(inst_a_ctrl === sa && inst_b_ctrl === sb && core_ctrl === sc, "R10", "idle keeps holds",
        {core_ctrl, inst_b_ctrl, inst_a_ctrl}, {sc, sb, sa});
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule